// File: doc/BRIEF.md
# Error-Tolerant Synchronous FIFO

A single-clock first-in first-out buffer of 2**ADDR_W words, each DATA_W bits wide. Beside the usual write and read enables, it has fixed rules for bad requests. A write that arrives while the buffer is full is turned away. A read that arrives while the buffer is empty returns a fill word. Two elaboration parameters choose these rules. `DROP_MODE` selects whether a write while full is refused or discarded. `HOLD_LAST` selects whether an empty read returns zero or the word most recently read out.

Every rejected write and every empty read is an error event. Each event bumps a 16-bit saturating counter for its kind. It also raises a one-cycle pulse, so a monitor can track errors without polling. Occupancy is reported as a count, with full, empty, almost-full and almost-empty flags derived from it. Read data is registered.

Top module: `err_tol_fifo`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, the block clears the level, both error counters, the read data register and the held word. Afterwards `empty`=1, `full`=0 and `data_count`=0.
- R2: Words are read out in the order they were accepted. A successful read puts its word on `rd_data` at the first clock edge after `rd_en` is sampled high.
- R3: A write with `full`=1 and `rd_en`=0 is not stored. The stored words and `data_count` are unchanged, and `ovf_count` goes up by one. This holds for both values of `DROP_MODE`.
- R4: With `HOLD_LAST`=0, a read while `empty`=1 drives all zeros onto `rd_data` one cycle later.
- R5: With `HOLD_LAST`=1, a read while empty returns the word of the most recent successful read, or zero if none has happened since reset. Empty reads do not change the held word.
- R6: `data_count` equals the number of stored words, from 0 to 2**ADDR_W. `full` is 1 exactly at 2**ADDR_W and `empty` is 1 exactly at 0.
- R7: `almost_full` is 1 exactly when 2**ADDR_W minus `data_count` is at most `AF_THR`.
- R8: `almost_empty` is 1 exactly when `data_count` is at most `AE_THR`.
- R9: A simultaneous read and write while full are both performed. The count stays at full and no overflow is counted.
- R10: A simultaneous read and write while empty stores the written word, leaving count 1, and counts one underflow.
- R11: `ovf_count` and `unf_count` are 16 bits wide. They hold at 16'hFFFF instead of wrapping.
- R12: `ovf_pulse` / `unf_pulse` is high for exactly the one cycle after each overflow / underflow event, including events past saturation. The matching counter shows the increment in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Registered read word or fill word |
| full | output | 1 | Level equals depth |
| empty | output | 1 | Level is zero |
| almost_full | output | 1 | Free slots at or below AF_THR |
| almost_empty | output | 1 | Level at or below AE_THR |
| data_count | output | ADDR_W+1 | Current level |
| ovf_count | output | ERR_W | Saturating overflow event count |
| unf_count | output | ERR_W | Saturating underflow event count |
| ovf_pulse | output | 1 | One-cycle overflow event marker |
| unf_pulse | output | 1 | One-cycle underflow event marker |

## Verification
Every result is due exactly one clock edge after the request that causes it. This covers the level and its flags, both counters, both pulses, and `rd_data`, including the fill word on an empty read. The driver applies a request just after a falling edge, lets one rising edge pass, and compares the level, flags, counters and pulses at the next falling edge. Each read pushes its expected word into a scoreboard queue. The monitor pops that entry on the falling edge after the rising edge that sampled the read, so the comparison always lands in the cycle the word becomes valid. Two instances, one per fill policy, share the stimulus.

// File: rtl/etf_pkg.sv
package etf_pkg;

    // Width of the error event counters.
    localparam int ERR_W_DEF = 16;

    // Classification of one cycle's request pair.
    typedef enum logic [1:0] {
        REQ_NONE  = 2'b00,
        REQ_READ  = 2'b01,
        REQ_WRITE = 2'b10,
        REQ_BOTH  = 2'b11
    } req_e;

endpackage

// File: rtl/etf_store.sv
module etf_store #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    // Storage carries no reset; validity is tracked by the pointers.
    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/etf_sat_cnt.sv
module etf_sat_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] value
);
    logic [W-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (inc && (val_q != {W{1'b1}})) begin
            val_d = val_q + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '0;
        end else begin
            val_q <= val_d;
        end
    end

    assign value = val_q;

endmodule

// File: rtl/etf_ctrl.sv
module etf_ctrl
    import etf_pkg::*;
#(
    parameter int ADDR_W    = 3,
    parameter int AF_THR    = 2,
    parameter int AE_THR    = 2,
    parameter int DROP_MODE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic              rd_req,
    output logic              wr_go,
    output logic              rd_go,
    output logic              ovf_evt,
    output logic              unf_evt,
    output logic [ADDR_W-1:0] wr_ptr,
    output logic [ADDR_W-1:0] rd_ptr,
    output logic [ADDR_W:0]   level,
    output logic              full,
    output logic              empty,
    output logic              afull,
    output logic              aempty
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int LVL_W = ADDR_W + 1;

    typedef struct packed {
        logic [ADDR_W-1:0] wp;
        logic [ADDR_W-1:0] rp;
        logic [LVL_W-1:0]  lvl;
    } ptr_t;

    ptr_t st_d, st_q;
    req_e req;

    assign full  = (st_q.lvl == LVL_W'(DEPTH));
    assign empty = (st_q.lvl == '0);
    assign rd_go = rd_req && !empty;

    // A read in the same cycle frees a slot, so a write alongside it always fits.
    generate
        if (DROP_MODE != 0) begin : g_drop
            // The incoming word is discarded when no slot is available.
            assign wr_go = wr_req && (!full || rd_go);
        end else begin : g_block
            // The request is refused; nothing downstream moves.
            assign wr_go = wr_req && !(full && !rd_go);
        end
    endgenerate

    assign ovf_evt = wr_req && !wr_go;
    assign unf_evt = rd_req && empty;

    always_comb begin
        st_d = st_q;
        req  = req_e'({wr_go, rd_go});
        if (wr_go) st_d.wp = st_q.wp + ADDR_W'(1);
        if (rd_go) st_d.rp = st_q.rp + ADDR_W'(1);
        case (req)
            REQ_WRITE: st_d.lvl = st_q.lvl + LVL_W'(1);
            REQ_READ:  st_d.lvl = st_q.lvl - LVL_W'(1);
            default:   st_d.lvl = st_q.lvl;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_ptr = st_q.wp;
    assign rd_ptr = st_q.rp;
    assign level  = st_q.lvl;
    assign afull  = (DEPTH - int'(st_q.lvl)) <= AF_THR;
    assign aempty = int'(st_q.lvl) <= AE_THR;

endmodule

// File: rtl/err_tol_fifo.sv
module err_tol_fifo
    import etf_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 3,
    parameter int AF_THR    = 2,
    parameter int AE_THR    = 2,
    parameter int DROP_MODE = 0,
    parameter int HOLD_LAST = 0,
    parameter int ERR_W     = ERR_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              full,
    output logic              empty,
    output logic              almost_full,
    output logic              almost_empty,
    output logic [ADDR_W:0]   data_count,
    output logic [ERR_W-1:0]  ovf_count,
    output logic [ERR_W-1:0]  unf_count,
    output logic              ovf_pulse,
    output logic              unf_pulse
);
    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              ovf_p;
        logic              unf_p;
    } out_t;

    logic              wr_go, rd_go, ovf_evt, unf_evt;
    logic [ADDR_W-1:0] wr_ptr, rd_ptr;
    logic [DATA_W-1:0] mem_word, fill_word;
    out_t              o_d, o_q;

    etf_ctrl #(
        .ADDR_W    (ADDR_W),
        .AF_THR    (AF_THR),
        .AE_THR    (AE_THR),
        .DROP_MODE (DROP_MODE)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_req  (wr_en),
        .rd_req  (rd_en),
        .wr_go   (wr_go),
        .rd_go   (rd_go),
        .ovf_evt (ovf_evt),
        .unf_evt (unf_evt),
        .wr_ptr  (wr_ptr),
        .rd_ptr  (rd_ptr),
        .level   (data_count),
        .full    (full),
        .empty   (empty),
        .afull   (almost_full),
        .aempty  (almost_empty)
    );

    etf_store #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_store (
        .clk   (clk),
        .we    (wr_go),
        .waddr (wr_ptr),
        .wdata (wr_data),
        .raddr (rd_ptr),
        .rdata (mem_word)
    );

    etf_sat_cnt #(.W(ERR_W)) u_ovf_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (ovf_evt),
        .value (ovf_count)
    );

    etf_sat_cnt #(.W(ERR_W)) u_unf_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (unf_evt),
        .value (unf_count)
    );

    // Fill word for an empty read: the parameter picks the source.
    generate
        if (HOLD_LAST != 0) begin : g_hold
            logic [DATA_W-1:0] last_d, last_q;

            always_comb begin
                last_d = last_q;
                if (rd_go) last_d = mem_word;
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    last_q <= '0;
                end else begin
                    last_q <= last_d;
                end
            end

            assign fill_word = last_q;
        end else begin : g_zero
            assign fill_word = '0;
        end
    endgenerate

    always_comb begin
        o_d       = o_q;
        o_d.ovf_p = ovf_evt;
        o_d.unf_p = unf_evt;
        if (rd_go) begin
            o_d.rdata = mem_word;
        end else if (unf_evt) begin
            o_d.rdata = fill_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign rd_data   = o_q.rdata;
    assign ovf_pulse = o_q.ovf_p;
    assign unf_pulse = o_q.unf_p;

endmodule

// File: rtl/etf_checker.sv
module etf_checker #(
    parameter int ADDR_W = 3,
    parameter int ERR_W  = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rd_en,
    input logic             full,
    input logic             empty,
    input logic [ADDR_W:0]  data_count,
    input logic [ERR_W-1:0] ovf_count,
    input logic [ERR_W-1:0] unf_count,
    input logic             ovf_pulse,
    input logic             unf_pulse
);
    localparam int DEPTH = 1 << ADDR_W;

    assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(data_count) <= DEPTH);

    assert_flag_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    assert_blocked_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en) |=> $stable(data_count));

    assert_full_rw_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && rd_en) |=> (full && !ovf_pulse));

    assert_empty_rw_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && wr_en && rd_en) |=> (int'(data_count) == 1 && unf_pulse));

    assert_ovf_sat_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_count == {ERR_W{1'b1}}) |=> (ovf_count == {ERR_W{1'b1}}));

    assert_unf_sat_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (unf_count == {ERR_W{1'b1}}) |=> (unf_count == {ERR_W{1'b1}}));

    assert_ovf_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && !rd_en) |=> (ovf_pulse && ovf_count != '0));

    assert_unf_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty) |=> (unf_pulse && unf_count != '0));

endmodule

bind err_tol_fifo etf_checker #(
    .ADDR_W (ADDR_W),
    .ERR_W  (ERR_W)
) u_etf_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .full       (full),
    .empty      (empty),
    .data_count (data_count),
    .ovf_count  (ovf_count),
    .unf_count  (unf_count),
    .ovf_pulse  (ovf_pulse),
    .unf_pulse  (unf_pulse)
);

// File: tb/tb_err_tol_fifo.sv
`timescale 1ns/1ps
module tb_err_tol_fifo;
    localparam int DW    = 8;
    localparam int AW    = 3;
    localparam int DEPTH = 1 << AW;
    localparam int AFT   = 2;
    localparam int AET   = 2;

    typedef struct {
        logic [DW-1:0] d0;
        logic [DW-1:0] dh;
        string         tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic rd_en = 1'b0;
    logic [DW-1:0] wr_data = '0;

    logic [DW-1:0] rd0, rdh;
    logic full0, empty0, af0, ae0, fullh, emptyh, afh, aeh;
    logic [AW:0] cnt0, cnth;
    logic [15:0] ovc0, unc0, ovch, unch;
    logic ovp0, unp0, ovph, unph;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    logic rd_seen = 1'b0;

    logic [DW-1:0] mq[$];
    exp_t sbq[$];
    logic [DW-1:0] last_h = '0;
    logic [15:0] m_ovf = '0;
    logic [15:0] m_unf = '0;
    exp_t mx;

    always #10 clk = ~clk;

    err_tol_fifo #(.DATA_W(DW), .ADDR_W(AW), .AF_THR(AFT), .AE_THR(AET),
                   .DROP_MODE(0), .HOLD_LAST(0), .ERR_W(16)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd0), .full(full0), .empty(empty0), .almost_full(af0),
        .almost_empty(ae0), .data_count(cnt0), .ovf_count(ovc0), .unf_count(unc0),
        .ovf_pulse(ovp0), .unf_pulse(unp0));

    err_tol_fifo #(.DATA_W(DW), .ADDR_W(AW), .AF_THR(AFT), .AE_THR(AET),
                   .DROP_MODE(1), .HOLD_LAST(1), .ERR_W(16)) dut_h (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rdh), .full(fullh), .empty(emptyh), .almost_full(afh),
        .almost_empty(aeh), .data_count(cnth), .ovf_count(ovch), .unf_count(unch),
        .ovf_pulse(ovph), .unf_pulse(unph));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: a read sampled at a rising edge is compared at the next falling edge.
    always @(posedge clk) rd_seen <= rst_n && rd_en;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (sbq.size() == 0) begin
                chk("R2 scoreboard underrun", 32'd0, 32'd1);
            end else begin
                mx = sbq.pop_front();
                chk({mx.tag, " rd_data zero-fill instance"}, 32'(rd0), 32'(mx.d0));
                chk({mx.tag, " rd_data hold-last instance"}, 32'(rdh), 32'(mx.dh));
            end
        end
    end

    // Driver: one request cycle, model update, then state checks one edge later.
    task automatic step(input bit w, input logic [DW-1:0] d, input bit r, input bit chk_all);
        bit f, e, rok, wok, ov, un;
        exp_t x;
        f   = (mq.size() == DEPTH);
        e   = (mq.size() == 0);
        rok = r && !e;
        wok = w && (!f || rok);
        ov  = w && !wok;
        un  = r && e;
        x.d0 = '0; x.dh = '0; x.tag = "R2";
        if (rok) begin
            x.d0 = mq.pop_front();
            x.dh = x.d0;
            last_h = x.d0;
        end else if (un) begin
            x.d0 = '0;
            x.dh = last_h;
            x.tag = "R4 R5 fill";
        end
        if (r) sbq.push_back(x);
        if (wok) mq.push_back(d);
        if (ov && m_ovf != 16'hFFFF) m_ovf++;
        if (un && m_unf != 16'hFFFF) m_unf++;
        wr_en = w; wr_data = d; rd_en = r;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        if (chk_all) begin
            chk("R6 data_count", 32'(cnt0), 32'(mq.size()));
            chk("R6 data_count hold inst", 32'(cnth), 32'(mq.size()));
            chk("R6 full", 32'(full0), 32'(mq.size() == DEPTH));
            chk("R6 empty", 32'(empty0), 32'(mq.size() == 0));
            chk("R7 almost_full", 32'(af0), 32'((DEPTH - mq.size()) <= AFT));
            chk("R8 almost_empty", 32'(ae0), 32'(mq.size() <= AET));
            chk("R11 ovf_count", 32'(ovc0), 32'(m_ovf));
            chk("R11 ovf_count hold inst", 32'(ovch), 32'(m_ovf));
            chk("R11 unf_count", 32'(unc0), 32'(m_unf));
            chk("R11 unf_count hold inst", 32'(unch), 32'(m_unf));
            chk("R12 ovf_pulse", 32'(ovp0), 32'(ov));
            chk("R12 ovf_pulse hold inst", 32'(ovph), 32'(ov));
            chk("R12 unf_pulse", 32'(unp0), 32'(un));
            chk("R12 unf_pulse hold inst", 32'(unph), 32'(un));
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        mq.delete(); sbq.delete();
        last_h = '0; m_ovf = '0; m_unf = '0;
        // R1: state right after reset release
        chk("R1 data_count", 32'(cnt0), 32'd0);
        chk("R1 empty", 32'(empty0), 32'd1);
        chk("R1 full", 32'(full0), 32'd0);
        chk("R1 ovf_count", 32'(ovc0), 32'd0);
        chk("R1 unf_count", 32'(unch), 32'd0);
        chk("R1 rd_data", 32'(rd0), 32'd0);
        chk("R1 rd_data hold inst", 32'(rdh), 32'd0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        do_reset();
        // R4 R5: empty read right after reset; hold instance returns zero
        step(0, 8'h00, 1, 1);
        // fill to full, flags checked at each level (R6 R7 R8)
        for (int i = 0; i < DEPTH; i++) step(1, 8'hA0 + 8'(i), 0, 1);
        // R3: write while full is refused, level stays, one overflow
        step(1, 8'hEE, 0, 1);
        step(1, 8'hEF, 0, 1);
        // R9: read and write while full
        step(1, 8'h55, 1, 1);
        chk("R9 still full", 32'(full0), 32'd1);
        // R2: drain in order; refused words never appear
        for (int i = 0; i < DEPTH; i++) step(0, 8'h00, 1, 1);
        // R4 R5: empty read, zero vs last word 0x55
        step(0, 8'h00, 1, 1);
        // R10: read and write while empty
        step(1, 8'h66, 1, 1);
        chk("R10 one word stored", 32'(cnt0), 32'd1);
        step(0, 8'h00, 1, 1);
        step(0, 8'h00, 1, 1);
        // mixed pattern
        step(1, 8'h11, 0, 1);
        step(1, 8'h22, 1, 1);
        step(1, 8'h33, 0, 1);
        step(0, 8'h00, 1, 1);
        step(1, 8'h44, 1, 1);
        step(0, 8'h00, 1, 1);
        step(0, 8'h00, 1, 1);
        // R1: mid-run reset clears held word
        step(1, 8'h77, 0, 1);
        step(0, 8'h00, 1, 1);
        @(negedge clk);
        do_reset();
        step(0, 8'h00, 1, 1);
        // R11: saturate underflow counter
        for (int i = 0; i < 65540; i++) step(0, 8'h00, 1, 0);
        step(0, 8'h00, 1, 1);
        chk("R11 unf saturated", 32'(unc0), 32'h0000FFFF);
        chk("R12 pulse past saturation", 32'(unph), 32'd1);
        @(negedge clk);
        @(negedge clk);
        finish_run();
    end

endmodule